// File: doc/BRIEF.md
# Video capture interrupt status controller

This block gathers the event pulses of a video capture front end into sticky status bits and raises one level interrupt to the processor. The front end supplies one-cycle pulses on a 16-bit event vector, aligned to the status bit positions: FIFO, sync and ancillary-data conditions. An internal line-length watchdog supplies the long-line event. Each status bit has a paired mask bit. A mask bit of 1 holds that bit's interrupt back. After reset all masks are 1, so every interrupt is disabled.

Software sees one 32-bit register through a plain register port with byte enables. The status bits sit in the upper half and are cleared by writing 1 to them. The masks sit in the lower half and are ordinary read/write storage. Mask bit n goes with status bit n+16. The interrupt output is a registered OR of every status bit whose mask is 0.

Top module: `vcap_irq_ctrl`

## Requirements
- R1: Register layout is fixed. Status bits are at [31:16] and mask bits are at [15:0], and mask bit n governs status bit n+16. The status sources, by bit, are:
  - 30: FIFO line wrap
  - 29: FIFO overflow
  - 28: FIFO threshold
  - 27: long line
  - 26: vertical timing / message missed
  - 25: active-pixel count
  - 24: capture clock
  - 23: ancillary checksum/parity
  - 22: message buffer / ancillary packet count
  - 21: vertical blanking end
  - 20: vertical blanking start
  - 19: even field start
  - 18: odd field start
  - 17: line target match

  Event input ev_i[k] feeds status bit k+16.
- R2: After reset the register reads 0x0000FFFE and irq_o is 0.
- R3: A pulse on a source sets its status bit at the next clock edge, whatever the mask. The bit stays set until software clears it.
- R4: A write with reg_be_i[2] or reg_be_i[3] set clears each status bit in the enabled byte whose write data bit is 1. Data bits that are 0 leave their status bits unchanged.
- R5: If a source pulses in the same cycle that its status bit is written with 1, the bit stays set.
- R6: reg_be_i[0] writes mask bits [7:0] and reg_be_i[1] writes mask bits [15:8]. A write with only the mask bytes enabled leaves status unchanged. Mask bit 0 is plain storage.
- R7: irq_o is 1 exactly one cycle after some status bit with mask 0 is set, and 0 one cycle after none is. A mask bit of 1 suppresses its source.
- R8: Status bits 31 and 16 always read 0. Writes do not change them, and neither do pulses on ev_i[15] or ev_i[0]. ev_i[11] has no effect, because bit 27 is driven only by the watchdog.
- R9: A line lasts from one line_start_i pulse to the next. Bit 27 is set LINE_LIMIT cycles after a line start if no new start has come, so a line longer than LINE_LIMIT cycles flags the error and a line of exactly LINE_LIMIT cycles does not. Before the first line start it never fires.
- R10: The long-line event fires at most once per line. The watchdog counter saturates until the next line start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_i | input | 16 | Event pulses aligned to status bits 31:16 |
| line_start_i | input | 1 | One-cycle pulse at each line start |
| reg_wr_i | input | 1 | Register write strobe |
| reg_be_i | input | 4 | Byte enables of the write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Current register value |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench sets a source pulse against a write-1-to-clear of the same bit in one cycle. A design that let the clear win would lose an event, and irq_o would drop. It issues writes with only the mask bytes enabled but with all ones in the status half. A design that ignored the byte enables would wipe pending status. It runs lines of exactly LINE_LIMIT and LINE_LIMIT+1 cycles, and an off-by-one watchdog gets one of the two wrong. It then waits well past the limit after clearing the long-line bit, which catches a counter that wraps or re-fires within one line.

// File: rtl/vcap_irq_ctrl.sv
module vcap_irq_ctrl #(
  parameter int LINE_LIMIT = 3000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] ev_i,
  input  logic        line_start_i,
  input  logic        reg_wr_i,
  input  logic [3:0]  reg_be_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        irq_o
);
  localparam int CW = $clog2(LINE_LIMIT + 1);
  localparam logic [CW-1:0] LIM    = CW'(LINE_LIMIT);
  localparam logic [CW-1:0] LIM_M1 = CW'(LINE_LIMIT - 1);
  localparam int LONG_BIT = 11;
  localparam logic [15:0] LIVE   = 16'h7FFE;
  localparam logic [15:0] EXT    = LIVE & ~(16'h1 << LONG_BIT);
  localparam logic [15:0] MSK_RST = 16'hFFFE;

  logic [15:0]   sts_q, msk_q;
  logic [CW-1:0] cnt_q;
  logic          irq_q;
  logic          long_ev;
  logic [15:0]   ev_set, clr;

  assign long_ev = !line_start_i && (cnt_q == LIM_M1);
  assign ev_set  = (ev_i & EXT) | (16'(long_ev) << LONG_BIT);
  assign clr     = reg_wr_i ? (reg_wdata_i[31:16] & {{8{reg_be_i[3]}}, {8{reg_be_i[2]}}}) : 16'h0;

  always_ff @(posedge clk) begin
    if (!rst_n) sts_q <= 16'h0;
    else        sts_q <= ((sts_q & ~clr) | ev_set) & LIVE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) msk_q <= MSK_RST;
    else if (reg_wr_i) begin
      if (reg_be_i[0]) msk_q[7:0]  <= reg_wdata_i[7:0];
      if (reg_be_i[1]) msk_q[15:8] <= reg_wdata_i[15:8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= LIM;
    else if (line_start_i)    cnt_q <= '0;
    else if (cnt_q != LIM)    cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(sts_q & ~msk_q);
  end

  assign reg_rdata_o = {sts_q, msk_q};
  assign irq_o       = irq_q;

  // R3
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr_i |=> ((sts_q & $past(sts_q)) == $past(sts_q)));

  // R5
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i[2] && reg_wr_i && reg_be_i[2] && reg_wdata_i[18]) |=> reg_rdata_o[18]);

  // R6
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_i && (reg_be_i[0] || reg_be_i[1])) |=> $stable(msk_q));

  // R7
  irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts_q & ~msk_q) == 16'h0) |=> !irq_o);

  // R7
  irq_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts_q & ~msk_q) != 16'h0) |=> irq_o);

  // R8
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata_o[31] && !reg_rdata_o[16]);

  // R10
  once_per_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    long_ev |=> !long_ev);
endmodule

// File: tb/sim_vcap_irq_ctrl.sv
`timescale 1ns/1ps
module sim_vcap_irq_ctrl;
  localparam int LIM = 3000;
  logic clk = 0, rst_n = 0;
  logic [15:0] ev_i = '0;
  logic line_start_i = 0, reg_wr_i = 0;
  logic [3:0] reg_be_i = '0;
  logic [31:0] reg_wdata_i = '0, reg_rdata_o;
  logic irq_o;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vcap_irq_ctrl #(.LINE_LIMIT(LIM)) u0 (
    .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .line_start_i(line_start_i),
    .reg_wr_i(reg_wr_i), .reg_be_i(reg_be_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .irq_o(irq_o));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    ev_i = '0; line_start_i = 0; reg_wr_i = 0; reg_be_i = '0; reg_wdata_i = '0;
  endtask

  task automatic wr(input logic [3:0] be, input logic [31:0] d);
    reg_wr_i = 1; reg_be_i = be; reg_wdata_i = d; tick();
  endtask

  task automatic pulse(input logic [15:0] e);
    ev_i = e; tick();
  endtask

  task automatic run_line(input int len);
    line_start_i = 1; tick();
    repeat (len - 1) tick();
  endtask

  task automatic t_reset();
    chk("R2 reset value", reg_rdata_o, 32'h0000FFFE);
    chk("R2 reset irq", {31'b0, irq_o}, 0);
  endtask

  task automatic t_latch_masked();
    pulse(16'hFFFF);
    chk("R1 R3 R8 latch all sources", reg_rdata_o, 32'h77FEFFFE);
    tick();
    chk("R3 masked, no irq", {31'b0, irq_o}, 0);
  endtask

  task automatic t_clear();
    wr(4'b1100, 32'hFFFE_FFFF & 32'h0006_0000);
    chk("R4 w1c bits 17,18", reg_rdata_o, 32'h77F8FFFE);
    wr(4'b0100, 32'h8001_0000);
    chk("R8 reserved write", reg_rdata_o, 32'h77F8FFFE);
    wr(4'b1000, 32'h0000_0000);
    chk("R4 zero writes keep", reg_rdata_o, 32'h77F8FFFE);
  endtask

  task automatic t_mask_write();
    wr(4'b0011, 32'hFFFF_FFFB);
    chk("R6 mask-only write", reg_rdata_o, 32'h77F8FFFB);
    tick();
    chk("R7 enabled but no status", {31'b0, irq_o}, 0);
    wr(4'b0001, 32'h0000_00FF);
    chk("R6 low byte, bit0 storage", reg_rdata_o, 32'h77F8FFFF);
    wr(4'b0001, 32'h0000_00FB);
    pulse(16'h0004);
    chk("R3 odd field latched", reg_rdata_o, 32'h77FCFFFB);
    chk("R7 irq not yet", {31'b0, irq_o}, 0);
    tick();
    chk("R7 irq one cycle later", {31'b0, irq_o}, 1);
  endtask

  task automatic t_collide();
    ev_i = 16'h0004; wr(4'b0100, 32'h0004_0000);
    chk("R5 event beats clear", {31'b0, reg_rdata_o[18]}, 1);
    chk("R5 irq held", {31'b0, irq_o}, 1);
    wr(4'b0100, 32'h0004_0000);
    chk("R4 clear alone", {31'b0, reg_rdata_o[18]}, 0);
    chk("R7 irq lags clear", {31'b0, irq_o}, 1);
    tick();
    chk("R7 irq drops", {31'b0, irq_o}, 0);
    wr(4'b0011, 32'h0000_7FFF);
    wr(4'b0001, 32'h0000_00FE);
    tick();
    chk("R7 masked status no irq", {31'b0, irq_o}, 0);
  endtask

  task automatic t_watchdog();
    wr(4'b1100, 32'hFFFF_0000);
    chk("R4 clear all", reg_rdata_o[31:16], 0);
    repeat (LIM + 20) tick();
    chk("R9 idle before first line", {31'b0, reg_rdata_o[27]}, 0);
    run_line(LIM);
    run_line(5);
    chk("R9 exact limit no error", {31'b0, reg_rdata_o[27]}, 0);
    run_line(LIM + 1);
    chk("R9 limit+1 flags", {31'b0, reg_rdata_o[27]}, 1);
    wr(4'b1000, 32'h0800_0000);
    chk("R4 long clear", {31'b0, reg_rdata_o[27]}, 0);
    repeat (2 * LIM) tick();
    chk("R10 once per line", {31'b0, reg_rdata_o[27]}, 0);
    wr(4'b0010, 32'h0000_F700);
    run_line(LIM + 1);
    tick();
    chk("R7 R9 long line irq", {31'b0, irq_o}, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_latch_masked();
    t_clear();
    t_mask_write();
    t_collide();
    t_watchdog();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule